// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the arithmetic and logic stage of a small multi-cycle processor core. In one cycle it combines two operands under a 4-bit operation code and returns the result. It also computes the negative, zero, carry and overflow condition flags. The flags are held in a status register inside the block, and the carry-with operations read back the stored carry from that register.

The operand shifter sits upstream of this block. The shifter passes in its own carry-out and a marker that says the shift was a left shift by zero. Logical operations use these two inputs to decide the new carry flag. The sequencer asserts `en_i` in the execute phase. It also supplies the set-flags bit and the destination register index. An operation aimed at register 15 never changes the flags.

Top module: `dp_alu`

## Requirements
- R1: Logical codes give these results: 0x0 A&B, 0x1 A^B, 0x8 A&B, 0x9 A^B, 0xC A|B, 0xD B, 0xE A&~B, 0xF ~B.
- R2: Arithmetic codes give these results, where C is the stored carry flag: 0x2 A+~B+1, 0x3 B+~A+1, 0x4 A+B, 0x5 A+B+C, 0x6 A+~B+C, 0x7 B+~A+C, 0xA A+~B+1, 0xB A+B.
- R3: `result_we_o` is low for codes 0x8 to 0xB. For every other code it is high whenever `en_i` is high, and it is low when `en_i` is low.
- R4: The flags change on a clock edge only when all of the following hold: `en_i` is high, `rd_i` is not 15, and either `set_flags_i` is high or the code is one of 0x8 to 0xB. Otherwise they hold their value.
- R5: On an update, N takes bit 31 of the result, and Z is set only when the 32-bit result is zero.
- R6: On an arithmetic update, C takes bit 32 of the 33-bit zero-extended sum. V is set on signed overflow into bit 31.
- R7: On a logical update, V keeps its value and C takes `shift_carry_i`.
- R8: On a logical update with `shift_lsl0_i` high, C keeps its value.
- R9: Reset clears all flags to zero. `flags_o` is ordered {N,Z,C,V}, with N in bit 3 and V in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Operation issued this cycle |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand (shifter output) |
| shift_carry_i | input | 1 | Carry-out of the operand shifter |
| shift_lsl0_i | input | 1 | Shift was a left shift by zero |
| set_flags_i | input | 1 | Update the flags for this operation |
| rd_i | input | 4 | Destination register index |
| result_o | output | 32 | Operation result (combinational) |
| result_we_o | output | 1 | Write the result to the destination |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The assertions assume that `op_i`, the operands, `rd_i` and the shifter inputs are stable and free of X whenever `en_i` is high. They also assume that `en_i` is sampled only on rising edges. The bench changes every input on the falling clock edge and holds it through the next rising edge, so each operation is seen whole on exactly one edge. The vectors are run in a fixed order because each expected flag value depends on the flags left by the vector before it.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND  = 4'h0, OP_XOR  = 4'h1, OP_SUB  = 4'h2, OP_RSUB  = 4'h3,
    OP_ADD  = 4'h4, OP_ADDC = 4'h5, OP_SUBC = 4'h6, OP_RSUBC = 4'h7,
    OP_TAND = 4'h8, OP_TXOR = 4'h9, OP_CMP  = 4'hA, OP_CMPN  = 4'hB,
    OP_OR   = 4'hC, OP_MOVE = 4'hD, OP_CLR  = 4'hE, OP_MOVN  = 4'hF
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  function automatic logic op_is_arith(op_e op);
    return (op inside {OP_SUB, OP_RSUB, OP_ADD, OP_ADDC, OP_SUBC, OP_RSUBC, OP_CMP, OP_CMPN});
  endfunction

  function automatic logic op_is_test(op_e op);
    return (op inside {OP_TAND, OP_TXOR, OP_CMP, OP_CMPN});
  endfunction
endpackage

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  op_e           op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND, OP_TAND: res_o = a_i & b_i;
      OP_XOR, OP_TXOR: res_o = a_i ^ b_i;
      OP_OR:           res_o = a_i | b_i;
      OP_MOVE:         res_o = b_i;
      OP_CLR:          res_o = a_i & ~b_i;
      OP_MOVN:         res_o = ~b_i;
      default:         res_o = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu_arith.sv
module dp_alu_arith
  import dp_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  op_e           op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          c_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o,
  output logic          ovf_o
);
  localparam int SW = DW + 1;

  logic [DW-1:0] x, y;
  logic          cin;
  logic [SW-1:0] sum;

  // subtraction as x + ~y + carry; reverse forms swap operands
  always_comb begin
    x = a_i; y = b_i; cin = 1'b0;
    unique case (op_i)
      OP_SUB, OP_CMP: begin y = ~b_i; cin = 1'b1; end
      OP_RSUB:        begin x = b_i; y = ~a_i; cin = 1'b1; end
      OP_ADDC:        cin = c_i;
      OP_SUBC:        begin y = ~b_i; cin = c_i; end
      OP_RSUBC:       begin x = b_i; y = ~a_i; cin = c_i; end
      default:        ;
    endcase
  end

  assign sum    = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
  assign res_o  = sum[DW-1:0];
  assign cout_o = sum[DW];
  assign ovf_o  = (x[DW-1] == y[DW-1]) && (sum[DW-1] != x[DW-1]);

  // R6: two operands of opposite sign can never overflow
  always_comb begin
    if (a_i[DW-1] != b_i[DW-1] && op_i == OP_ADD)
      p_no_overflow_r6: assert (!ovf_o);
  end
endmodule

// File: rtl/dp_alu_flag_reg.sv
module dp_alu_flag_reg
  import dp_alu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   upd_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (upd_i) q_o <= d_i;
  end

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(q_o));
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          shift_carry_i,
  input  logic          shift_lsl0_i,
  input  logic          set_flags_i,
  input  logic [RW-1:0] rd_i,
  output logic [DW-1:0] result_o,
  output logic          result_we_o,
  output logic [3:0]    flags_o
);
  localparam logic [RW-1:0] PC_IDX = RW'((1 << RW) - 1);

  op_e           op;
  flags_t        fq, fd;
  logic [DW-1:0] log_res, ar_res;
  logic          ar_cout, ar_ovf, arith, upd;

  assign op    = op_e'(op_i);
  assign arith = op_is_arith(op);

  dp_alu_logic #(.DW(DW)) u_logic (
    .op_i(op), .a_i(a_i), .b_i(b_i), .res_o(log_res)
  );

  dp_alu_arith #(.DW(DW)) u_arith (
    .op_i(op), .a_i(a_i), .b_i(b_i), .c_i(fq.c),
    .res_o(ar_res), .cout_o(ar_cout), .ovf_o(ar_ovf)
  );

  assign result_o    = arith ? ar_res : log_res;
  assign result_we_o = en_i && !op_is_test(op);
  assign upd         = en_i && (rd_i != PC_IDX) && (set_flags_i || op_is_test(op));

  always_comb begin
    fd.n = result_o[DW-1];
    fd.z = (result_o == '0);
    if (arith) begin
      fd.c = ar_cout;
      fd.v = ar_ovf;
    end else begin
      fd.c = shift_lsl0_i ? fq.c : shift_carry_i;
      fd.v = fq.v;
    end
  end

  dp_alu_flag_reg u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd), .d_i(fd), .q_o(fq)
  );

  assign flags_o = fq;

  p_pc_dest_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rd_i == PC_IDX) |=> $stable(flags_o));

  p_test_no_we_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[3:2] == 2'b10) |-> !result_we_o);

  p_zero_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> (flags_o[2] == ($past(result_o) == '0)) && (flags_o[3] == $past(result_o[DW-1])));

  p_v_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && !arith) |=> flags_o[0] == $past(flags_o[0]));

  p_c_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && !arith && shift_lsl0_i) |=> flags_o[1] == $past(flags_o[1]));
endmodule

// File: tb/dp_alu_tb_top.sv
module dp_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic        shc = 1'b0, lsl0 = 1'b0, sf = 1'b0;
  logic [3:0]  rd = '0;
  logic [31:0] res;
  logic        we;
  logic [3:0]  flags;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dp_alu dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .op_i(op), .a_i(a), .b_i(b),
    .shift_carry_i(shc), .shift_lsl0_i(lsl0), .set_flags_i(sf), .rd_i(rd),
    .result_o(res), .result_we_o(we), .flags_o(flags)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic        shc;
    logic        lsl0;
    logic        sf;
    logic [3:0]  rd;
    logic [31:0] res;
    logic        we;
    logic [3:0]  flg;
  } vec_t;

  localparam int NV = 21;
  // flags after each vector, {N,Z,C,V}; run in order
  localparam vec_t VEC [NV] = '{
    '{4'h4, 32'hFFFFFFFF, 32'h1,        1'b0, 1'b0, 1'b1, 4'd0,  32'h0,        1'b1, 4'b0110}, // R6 carry
    '{4'h4, 32'h7FFFFFFF, 32'h1,        1'b0, 1'b0, 1'b1, 4'd0,  32'h80000000, 1'b1, 4'b1001}, // R6 ovf
    '{4'h0, 32'hF0F0F0F0, 32'h0F0F0F0F, 1'b0, 1'b0, 1'b1, 4'd1,  32'h0,        1'b1, 4'b0101}, // R7
    '{4'hC, 32'h80000000, 32'h1,        1'b1, 1'b1, 1'b1, 4'd2,  32'h80000001, 1'b1, 4'b1001}, // R8
    '{4'h1, 32'hFF,       32'h0F,       1'b1, 1'b0, 1'b1, 4'd3,  32'hF0,       1'b1, 4'b0011}, // R7
    '{4'h4, 32'h0,        32'h0,        1'b0, 1'b0, 1'b0, 4'd4,  32'h0,        1'b1, 4'b0011}, // R4 no S
    '{4'h4, 32'h0,        32'h0,        1'b0, 1'b0, 1'b1, 4'd15, 32'h0,        1'b1, 4'b0011}, // R4 pc
    '{4'h2, 32'h5,        32'h7,        1'b0, 1'b0, 1'b1, 4'd0,  32'hFFFFFFFE, 1'b1, 4'b1000}, // R2
    '{4'hA, 32'h7,        32'h7,        1'b0, 1'b0, 1'b0, 4'd0,  32'h0,        1'b0, 4'b0110}, // R3
    '{4'h5, 32'h1,        32'h2,        1'b0, 1'b0, 1'b1, 4'd0,  32'h4,        1'b1, 4'b0000}, // R2 adc
    '{4'h6, 32'd10,       32'd3,        1'b0, 1'b0, 1'b1, 4'd0,  32'd6,        1'b1, 4'b0010}, // R2 sbc
    '{4'h7, 32'd3,        32'd10,       1'b0, 1'b0, 1'b1, 4'd0,  32'd7,        1'b1, 4'b0010}, // R2 rsc
    '{4'h3, 32'd10,       32'd3,        1'b0, 1'b0, 1'b1, 4'd0,  32'hFFFFFFF9, 1'b1, 4'b1000}, // R2 rsb
    '{4'h8, 32'hF,        32'h10,       1'b1, 1'b0, 1'b0, 4'd0,  32'h0,        1'b0, 4'b0110}, // R1 R3
    '{4'h9, 32'h80000000, 32'h0,        1'b0, 1'b1, 1'b0, 4'd0,  32'h80000000, 1'b0, 4'b1010}, // R8
    '{4'hB, 32'h80000000, 32'h80000000, 1'b0, 1'b0, 1'b0, 4'd0,  32'h0,        1'b0, 4'b0111}, // R6
    '{4'hE, 32'hFF,       32'h0F,       1'b0, 1'b0, 1'b1, 4'd0,  32'hF0,       1'b1, 4'b0001}, // R1
    '{4'hF, 32'h0,        32'h0,        1'b1, 1'b0, 1'b1, 4'd0,  32'hFFFFFFFF, 1'b1, 4'b1011}, // R1
    '{4'h2, 32'h80000000, 32'h1,        1'b0, 1'b0, 1'b1, 4'd0,  32'h7FFFFFFF, 1'b1, 4'b0011}, // R6
    '{4'hA, 32'h1,        32'h1,        1'b0, 1'b0, 1'b0, 4'd15, 32'h0,        1'b0, 4'b0011}, // R4 pc
    '{4'hD, 32'h0,        32'h1234,     1'b0, 1'b0, 1'b0, 4'd0,  32'h1234,     1'b1, 4'b0011}  // R1
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #400000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R9 reset flags", {28'h0, flags}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      en = 1'b1; op = VEC[i].op; a = VEC[i].a; b = VEC[i].b;
      shc = VEC[i].shc; lsl0 = VEC[i].lsl0; sf = VEC[i].sf; rd = VEC[i].rd;
      #1;
      check($sformatf("R1/R2 result v%0d", i), res, VEC[i].res);
      check($sformatf("R3 we v%0d", i), {31'h0, we}, {31'h0, VEC[i].we});
      @(posedge clk); #1;
      check($sformatf("R4-R8 flags v%0d", i), {28'h0, flags}, {28'h0, VEC[i].flg});
      @(negedge clk);
    end

    // R3/R4: idle cycle with flags-setting add must not write or update
    en = 1'b0; op = 4'h4; a = 32'h0; b = 32'h0; sf = 1'b1; rd = 4'd0;
    #1;
    check("R3 we idle", {31'h0, we}, 32'h0);
    @(posedge clk); #1;
    check("R4 idle hold", {28'h0, flags}, 32'h3);

    // R9: reset mid-run clears flags
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 async clear", {28'h0, flags}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: LSL0 after reset keeps C=0 despite shifter carry
    en = 1'b1; op = 4'hD; b = 32'h5; shc = 1'b1; lsl0 = 1'b1; sf = 1'b1;
    @(posedge clk); #1;
    check("R8 lsl0 keep", {28'h0, flags}, 32'h0);
    @(negedge clk);
    en = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule